// File: doc/BRIEF.md
# PCI Interrupt Swizzle Router

This block collects the four level-sensitive interrupt pins (INTA through INTD) of every device slot on a PCI bus and merges them onto four system interrupt lines. The default routing rotates each pin by its slot number plus a fixed offset. The offset is chosen by a board-variant strap: variant A adds 2 and variant B adds 3. Every pin that routes to the same line is ORed into it, so several devices can share one system interrupt.

Older system software programmed interrupts as if pin N always reached line N. To stay compatible with it, the router snoops configuration writes. On variant A, the first write to a device's interrupt-line register, made on a slot where the two routings differ, settles the mapping for good. If the value written is 27, the router drops to the legacy identity mapping. Any other value locks the rotated mapping. Only a reset clears that decision. The detector state is brought out on a debug port.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all four `sys_irq` lines are 0 and `det_state` reads 0 (undecided). The other encodings are 1 (legacy) and 2 (locked rotated). The value 3 never appears.
- R2: On variant A (`variant_b`=0), when not in legacy, pin p of slot s drives line (s+p+2) mod 4. For example, slot 31 pins A/B/C/D drive lines 1/2/3/0, and slot 29 drives lines 3/0/1/2.
- R3: On variant B (`variant_b`=1), pin p of slot s drives line (s+p+3) mod 4. For example, slot 31 drives lines 2/3/0/1, and slot 29 drives lines 0/1/2/3.
- R4: Each system line is the OR of every slot/pin routed to it. A line stays high while any of its sources is high, and drops only when all of them are low.
- R5: The lines are registered. A change on `dev_irq` reaches `sys_irq` at the first rising clock edge after the change.
- R6: On variant A, while undecided, a configuration write qualifies when address bits [7:0] equal 0x3C. The slot is address bits [15:11], and the function number is bits [10:8]. A qualifying write with data byte [7:0] equal to 27 moves `det_state` to 1 at the next edge. From then on, pin p of every slot drives line p.
- R7: A qualifying write with any other data byte moves `det_state` to 2, and the rotated routing of R2 stays in force.
- R8: Once `det_state` is 1 or 2, no further configuration write changes it until reset.
- R9: Writes addressed to a slot with slot mod 4 equal to 2 (slot bits [12:11] = 2'b10) are ignored by the detector.
- R10: On variant B, the detector never leaves state 0, whatever is written.
- R11: Writes to any offset other than 0x3C are ignored, as are cycles with `cfg_wr_valid` low. Only data bits [7:0] are compared, so 0xABCDEF1B counts as 27.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_b | input | 1 | Board strap: 0 = variant A (offset 2), 1 = variant B (offset 3) |
| dev_irq | input | NUM_SLOTS*4 | Device pin levels; bit 4*i+p is pin p of slot SLOT_BASE+i |
| cfg_wr_valid | input | 1 | Strobe for a snooped configuration write |
| cfg_wr_addr | input | ADDR_W | Configuration write address (slot [15:11], function [10:8], offset [7:0]) |
| cfg_wr_data | input | DATA_W | Configuration write data |
| sys_irq | output | 4 | Merged system interrupt lines |
| det_state | output | 2 | Detector state: 0 undecided, 1 legacy, 2 locked rotated |

## Verification
Routing is first driven with one pin at a time across all slots and pins, under both straps and under the legacy mapping. A wrong offset, slot term or mapping select therefore shows up as a line index off by one position. Two sources that share a line are then raised and dropped in turn, which separates a true OR merge from a last-writer or priority merge. The detector is fed writes that fall just outside the qualifying set: the wrong offset, the ignored slot, the strobe low, and variant B. These come before and after a decisive write, so both the qualification terms and the stickiness are exercised. A value of 27 with non-zero upper bytes confirms that only the low byte is compared.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int PINS_PER_SLOT = 4;
    localparam int NUM_SYS_LINES = 4;

    localparam logic [7:0] ILINE_OFFSET = 8'h3C;
    localparam logic [7:0] LEGACY_TOKEN = 8'd27;
    localparam logic [1:0] SLOT_SAME_MOD = 2'b10;

    localparam int ROT_OFFSET_A = 2;
    localparam int ROT_OFFSET_B = 3;

    typedef enum logic [1:0] {
        DET_UNDECIDED = 2'd0,
        DET_LEGACY    = 2'd1,
        DET_LOCKED    = 2'd2
    } det_state_e;

    function automatic logic [1:0] rotate_line(input int slot, input int pin, input int offs);
        return 2'((slot + pin + offs) % NUM_SYS_LINES);
    endfunction

endpackage

// File: rtl/irq_route_map.sv
module irq_route_map
    import irq_route_pkg::*;
#(
    parameter int SLOT_BASE = 29,
    parameter int NUM_SLOTS = 3
) (
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] src_lvl,
    input  logic                               use_b,
    input  logic                               use_legacy,
    output logic [NUM_SYS_LINES-1:0]           merged
);
    localparam int NUM_SRC = NUM_SLOTS * PINS_PER_SLOT;

    logic [1:0] tgt_a   [NUM_SRC];
    logic [1:0] tgt_b   [NUM_SRC];
    logic [1:0] tgt_id  [NUM_SRC];
    logic [1:0] tgt_sel [NUM_SRC];

    // Fixed per-source destinations, one per mapping
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar p = 0; p < PINS_PER_SLOT; p++) begin : g_pin
            localparam int IDX = s * PINS_PER_SLOT + p;
            assign tgt_a[IDX]  = rotate_line(SLOT_BASE + s, p, ROT_OFFSET_A);
            assign tgt_b[IDX]  = rotate_line(SLOT_BASE + s, p, ROT_OFFSET_B);
            assign tgt_id[IDX] = 2'(p);
            assign tgt_sel[IDX] = use_legacy ? tgt_id[IDX]
                                : (use_b ? tgt_b[IDX] : tgt_a[IDX]);
        end
    end

    always_comb begin
        merged = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_lvl[i]) begin
                merged[tgt_sel[i]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_line_snoop.sv
module irq_line_snoop
    import irq_route_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              variant_b,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output det_state_e        state
);
    typedef struct packed {
        det_state_e st;
    } snoop_regs_t;

    snoop_regs_t r_d, r_q;

    logic       off_hit;
    logic [4:0] slot_no;
    logic       slot_differs;
    logic       qualify;
    logic       token_hit;

    always_comb begin
        off_hit      = (wr_addr[7:0] == ILINE_OFFSET);
        slot_no      = wr_addr[15:11];
        slot_differs = (slot_no[1:0] != SLOT_SAME_MOD);
        token_hit    = (wr_data[7:0] == LEGACY_TOKEN);
        qualify      = wr_valid && !variant_b && off_hit && slot_differs
                       && (r_q.st == DET_UNDECIDED);

        r_d = r_q;
        if (qualify) begin
            r_d.st = token_hit ? DET_LEGACY : DET_LOCKED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= DET_UNDECIDED;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import irq_route_pkg::*;
#(
    parameter int SLOT_BASE = 29,
    parameter int NUM_SLOTS = 3,
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               variant_b,
    input  logic [NUM_SLOTS*PINS_PER_SLOT-1:0] dev_irq,
    input  logic                               cfg_wr_valid,
    input  logic [ADDR_W-1:0]                  cfg_wr_addr,
    input  logic [DATA_W-1:0]                  cfg_wr_data,
    output logic [NUM_SYS_LINES-1:0]           sys_irq,
    output logic [1:0]                         det_state
);
    localparam int NUM_LINES = NUM_SLOTS * PINS_PER_SLOT;

    typedef struct packed {
        logic [NUM_SYS_LINES-1:0] lines;
    } out_regs_t;

    out_regs_t o_d, o_q;

    det_state_e               snoop_st;
    logic [NUM_SYS_LINES-1:0] merged;

    irq_line_snoop #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .variant_b (variant_b),
        .wr_valid  (cfg_wr_valid),
        .wr_addr   (cfg_wr_addr),
        .wr_data   (cfg_wr_data),
        .state     (snoop_st)
    );

    irq_route_map #(
        .SLOT_BASE (SLOT_BASE),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_map (
        .src_lvl    (dev_irq),
        .use_b      (variant_b),
        .use_legacy (snoop_st == DET_LEGACY),
        .merged     (merged)
    );

    always_comb begin
        o_d       = o_q;
        o_d.lines = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q.lines <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign sys_irq   = o_q.lines;
    assign det_state = snoop_st;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 32,
    parameter int NUM_LINES = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 variant_b,
    input logic [NUM_LINES-1:0] dev_irq,
    input logic                 cfg_wr_valid,
    input logic [ADDR_W-1:0]    cfg_wr_addr,
    input logic [DATA_W-1:0]    cfg_wr_data,
    input logic [3:0]           sys_irq,
    input logic [1:0]           det_state
);
    logic cand;
    assign cand = cfg_wr_valid && !variant_b && (det_state == 2'd0)
                  && (cfg_wr_addr[7:0] == 8'h3C) && (cfg_wr_addr[12:11] != 2'b10);

    a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        det_state != 2'd3);

    a_r4_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_irq == '0) |=> (sys_irq == 4'd0));

    a_r6_to_legacy: assert property (@(posedge clk) disable iff (!rst_n)
        (cand && cfg_wr_data[7:0] == 8'd27) |=> (det_state == 2'd1));

    a_r7_to_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cand && cfg_wr_data[7:0] != 8'd27) |=> (det_state == 2'd2));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (det_state != 2'd0) |=> $stable(det_state));

    a_r9_same_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (det_state == 2'd0 && cfg_wr_addr[12:11] == 2'b10) |=> (det_state == 2'd0));

    a_r10_variant_b: assert property (@(posedge clk) disable iff (!rst_n)
        (det_state == 2'd0 && variant_b) |=> (det_state == 2'd0));

    a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (det_state == 2'd0 && !cfg_wr_valid) |=> (det_state == 2'd0));

endmodule

bind pci_irq_router irq_router_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .variant_b    (variant_b),
    .dev_irq      (dev_irq),
    .cfg_wr_valid (cfg_wr_valid),
    .cfg_wr_addr  (cfg_wr_addr),
    .cfg_wr_data  (cfg_wr_data),
    .sys_irq      (sys_irq),
    .det_state    (det_state)
);

// File: tb/sim_pci_irq_router.sv
`timescale 1ns/1ps
module sim_pci_irq_router;
    localparam int SLOT_BASE = 29;
    localparam int NUM_SLOTS = 3;
    localparam int NL = NUM_SLOTS * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          variant_b = 1'b0;
    logic [NL-1:0] dev_irq = '0;
    logic          cfg_wr_valid = 1'b0;
    logic [23:0]   cfg_wr_addr = '0;
    logic [31:0]   cfg_wr_data = '0;
    logic [3:0]    sys_irq;
    logic [1:0]    det_state;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pci_irq_router #(.SLOT_BASE(SLOT_BASE), .NUM_SLOTS(NUM_SLOTS)) u0 (
        .clk(clk), .rst_n(rst_n), .variant_b(variant_b), .dev_irq(dev_irq),
        .cfg_wr_valid(cfg_wr_valid), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_data(cfg_wr_data), .sys_irq(sys_irq), .det_state(det_state)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] cfg_addr(input int slot, input logic [7:0] off);
        return {8'h00, 5'(slot), 3'b000, off};
    endfunction

    task automatic do_reset(input logic vb);
        @(negedge clk);
        rst_n = 1'b0;
        variant_b = vb;
        dev_irq = '1;
        cfg_wr_valid = 1'b0;
        @(negedge clk);
        check("R1 lines in reset", {28'd0, sys_irq}, 32'd0);
        check("R1 state in reset", {30'd0, det_state}, 32'd0);
        dev_irq = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lines after reset", {28'd0, sys_irq}, 32'd0);
        check("R1 state after reset", {30'd0, det_state}, 32'd0);
    endtask

    task automatic cfg_write(input int slot, input logic [7:0] off, input logic [31:0] data,
                             input logic strobe);
        @(negedge clk);
        cfg_wr_valid = strobe;
        cfg_wr_addr = cfg_addr(slot, off);
        cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_valid = 1'b0;
    endtask

    // One source at a time; expected line from the requirement formula
    task automatic t_route(input string req, input logic vb, input logic legacy);
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int p = 0; p < 4; p++) begin
                int ln;
                ln = legacy ? p : ((SLOT_BASE + s + p + (vb ? 3 : 2)) % 4);
                @(negedge clk);
                dev_irq = '0;
                dev_irq[s*4+p] = 1'b1;
                @(negedge clk);
                check(req, {28'd0, sys_irq}, 32'(1 << ln));
            end
        end
        @(negedge clk);
        dev_irq = '0;
        @(negedge clk);
    endtask

    task automatic t_latency;
        @(negedge clk);
        dev_irq = '0;
        dev_irq[8] = 1'b1;          // slot 31 pin A -> line 1 on variant A
        #1;
        check("R5 not before edge", {28'd0, sys_irq}, 32'd0);
        @(negedge clk);
        check("R5 after one edge", {28'd0, sys_irq}, 32'd2);
        dev_irq = '0;
        @(negedge clk);
        check("R5 drop after one edge", {28'd0, sys_irq}, 32'd0);
    endtask

    task automatic t_share;
        // variant A: slot 29 pin B and slot 30 pin A both reach line 0
        @(negedge clk);
        dev_irq = '0;
        dev_irq[1] = 1'b1;
        dev_irq[4] = 1'b1;
        @(negedge clk);
        check("R4 both high", {28'd0, sys_irq}, 32'd1);
        dev_irq[1] = 1'b0;
        @(negedge clk);
        check("R4 one still high", {28'd0, sys_irq}, 32'd1);
        dev_irq[4] = 1'b0;
        @(negedge clk);
        check("R4 both low", {28'd0, sys_irq}, 32'd0);
        dev_irq = '1;
        @(negedge clk);
        check("R4 all sources", {28'd0, sys_irq}, 32'hF);
        dev_irq = '0;
        @(negedge clk);
    endtask

    task automatic t_legacy_path;
        do_reset(1'b0);
        cfg_write(30, 8'h3C, 32'd27, 1'b1);
        check("R9 slot 30 ignored", {30'd0, det_state}, 32'd0);
        cfg_write(31, 8'h3D, 32'd27, 1'b1);
        check("R11 other offset ignored", {30'd0, det_state}, 32'd0);
        cfg_write(31, 8'h3C, 32'd27, 1'b0);
        check("R11 no strobe ignored", {30'd0, det_state}, 32'd0);
        t_route("R2 still rotated", 1'b0, 1'b0);
        cfg_write(31, 8'h3C, 32'hABCDEF1B, 1'b1);
        check("R6 R11 low byte 27 to legacy", {30'd0, det_state}, 32'd1);
        t_route("R6 identity routing", 1'b0, 1'b1);
        cfg_write(29, 8'h3C, 32'd5, 1'b1);
        check("R8 legacy sticky", {30'd0, det_state}, 32'd1);
        t_route("R8 identity kept", 1'b0, 1'b1);
    endtask

    task automatic t_locked_path;
        do_reset(1'b0);
        cfg_write(29, 8'h3C, 32'h0000_1B05, 1'b1);
        check("R7 other value to locked", {30'd0, det_state}, 32'd2);
        t_route("R7 rotated kept", 1'b0, 1'b0);
        cfg_write(31, 8'h3C, 32'd27, 1'b1);
        check("R8 locked sticky", {30'd0, det_state}, 32'd2);
    endtask

    task automatic t_variant_b;
        do_reset(1'b1);
        t_route("R3 variant B routing", 1'b1, 1'b0);
        cfg_write(31, 8'h3C, 32'd27, 1'b1);
        check("R10 variant B no legacy", {30'd0, det_state}, 32'd0);
        cfg_write(29, 8'h3C, 32'd9, 1'b1);
        check("R10 variant B no lock", {30'd0, det_state}, 32'd0);
        t_route("R10 variant B routing kept", 1'b1, 1'b0);
    endtask

    initial begin
        do_reset(1'b0);
        t_route("R2 variant A routing", 1'b0, 1'b0);
        t_latency();
        t_share();
        t_legacy_path();
        t_locked_path();
        t_variant_b();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule